// File: doc/BRIEF.md
# Receive Byte Queue with Selectable Interrupt Level

This block holds received characters between a serial deserializer and the host register interface. It is an eight-entry first-in first-out store. Each entry holds a data byte and a special-condition flag that marks a character received with an error or at the end of a frame. The host sees the entry at the read head on `rd_data` and `rd_special`, and removes it with a `pop` strobe. `char_avail` tells the host whether more data is waiting after it has serviced an interrupt.

The host writes a small set of control registers through a byte-wide write port. Bit 0 of the register at address 15 is a redirect bit. While it is set, writes to address 7 update a shadow configuration byte instead of the ordinary register 7. Bit 3 of the shadow byte sets the interrupt level: either one character or half full (four characters). Bit 4 of the register at address 1 enables the receive interrupt for all characters and special conditions. At the half-full level, a flagged character found in any of the four entries nearest the read head raises the interrupt early. The interrupt is a level that is recomputed from the current fill state on every cycle.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset the queue is empty, `char_avail`, `overrun` and `irq` are 0, and `reg7_q` and `shadow_q` are 0.
- R2: Characters leave in the order they were accepted, up to 8 held. `rd_data` and `rd_special` always show the entry at the read head, and `char_avail` is 1 whenever at least one entry is held.
- R3: A push into a full queue with no pop in the same cycle is dropped and sets `overrun`. `overrun` stays set until an `err_reset` strobe. If an overrun occurs in the same cycle as `err_reset`, the set wins.
- R4: A push and a pop in the same cycle on a non-empty queue both take effect and leave the fill count unchanged. This includes a full queue, where the pop makes room and `overrun` is not set.
- R5: A write to address 7 updates `shadow_q` when bit 0 of the address-15 register is 1. Otherwise it updates `reg7_q`. The register that is not addressed keeps its value.
- R6: Bit 7 of `shadow_q` is reserved and always reads 0, whatever value is written. Bits 6..0 store the written value.
- R7: When shadow bit 3 is 0 and address-1 bit 4 is 1, `irq` is 1 exactly when at least one character is held.
- R8: When shadow bit 3 is 1 and address-1 bit 4 is 1, `irq` is 1 when at least 4 characters are held, or when a flagged character is held in one of the 4 entries nearest the read head.
- R9: When address-1 bit 4 is 0, `irq` is 0 regardless of fill level or flags.
- R10: `irq` follows the registered fill state: it falls in the cycle after a pop that takes the queue below the active condition.
- R11: A pop on an empty queue is ignored. The queue stays empty, `overrun` is unaffected, and the next pushed character is read correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Host register address |
| wr_data | input | 8 | Host register write data |
| push | input | 1 | Deserializer delivers a character |
| push_data | input | 8 | Received byte |
| push_special | input | 1 | Special-condition flag of the received byte |
| pop | input | 1 | Host removes the head character |
| err_reset | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 8 | Byte at the read head |
| rd_special | output | 1 | Special-condition flag at the read head |
| char_avail | output | 1 | At least one character held |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt request (level) |
| reg7_q | output | 8 | Ordinary register 7 contents |
| shadow_q | output | 8 | Shadow configuration byte |

## Verification
The assertions check the cycle-level bookkeeping on every cycle:
- the fill count steps up on a lone accepted push and holds on a push and pop together;
- a push into a full queue sets `overrun`, and `overrun` holds until it is cleared;
- an empty pop leaves the count unchanged, and the reserved shadow bit stays at 0;
- `irq` is forced low when disabled and is raised at either threshold.

Only the bench scenarios show the data ordering and the head-flag view through the scoreboard. They also show the redirect of address-7 writes and the early interrupt from a flagged character below the half mark. Finally, they show `irq` falling after the pop that crosses the threshold.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int RXF_DW = 8;

  typedef struct packed {
    logic              spec;
    logic [RXF_DW-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs #(
  parameter int ADDR_W   = 4,
  parameter int DW       = 8,
  parameter int CTL_ADDR = 1,
  parameter int CFG_ADDR = 7,
  parameter int SEL_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     ctl_q,
  output logic [DW-1:0]     reg7_q,
  output logic [DW-1:0]     shadow_q
);
  logic [DW-1:0] sel_q, sel_d, ctl_d, reg7_d, shadow_d;
  logic          hit_ctl, hit_cfg, hit_sel;

  assign hit_ctl = wr_en && (wr_addr == ADDR_W'(CTL_ADDR));
  assign hit_cfg = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
  assign hit_sel = wr_en && (wr_addr == ADDR_W'(SEL_ADDR));

  always_comb begin
    ctl_d    = ctl_q;
    sel_d    = sel_q;
    reg7_d   = reg7_q;
    shadow_d = shadow_q;
    if (hit_ctl) ctl_d = wr_data;
    if (hit_sel) sel_d = wr_data;
    if (hit_cfg) begin
      if (sel_q[0]) shadow_d = {1'b0, wr_data[DW-2:0]};
      else          reg7_d   = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      sel_q    <= '0;
      reg7_q   <= '0;
      shadow_q <= '0;
    end else begin
      ctl_q    <= ctl_d;
      sel_q    <= sel_d;
      reg7_q   <= reg7_d;
      shadow_q <= shadow_d;
    end
  end
endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HALF  = DEPTH / 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  rx_entry_t       push_entry,
  input  logic            pop,
  input  logic            err_clr,
  output rx_entry_t       head,
  output logic [CW-1:0]   count,
  output logic            ovr_q,
  output logic [HALF-1:0] spec_win
);
  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CW-1:0]   count_d;
  logic            do_push, do_pop, ovr_d;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != CW'(DEPTH)) || do_pop);

  always_comb begin
    wr_ptr_d = do_push ? wr_ptr + AW'(1) : wr_ptr;
    rd_ptr_d = do_pop  ? rd_ptr + AW'(1) : rd_ptr;
    count_d  = count + CW'(do_push) - CW'(do_pop);
    if (push && !do_push) ovr_d = 1'b1;
    else if (err_clr)     ovr_d = 1'b0;
    else                  ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  assign head = mem[rd_ptr];

  for (genvar k = 0; k < HALF; k++) begin : g_win
    logic [AW-1:0] idx;
    assign idx         = rd_ptr + AW'(k);
    assign spec_win[k] = (CW'(k) < count) && mem[idx].spec;
  end
endmodule

// File: rtl/rxf_irq_gen.sv
module rxf_irq_gen #(
  parameter int DEPTH = 8,
  parameter int HALF  = DEPTH / 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            rx_ie,
  input  logic            lvl_half,
  input  logic [CW-1:0]   count,
  input  logic [HALF-1:0] spec_win,
  output logic            irq
);
  logic data_cond;

  always_comb begin
    if (lvl_half) data_cond = (count >= CW'(HALF)) || (|spec_win);
    else          data_cond = (count != '0);
    irq = rx_ie && data_cond;
  end
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rxf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 4,
  parameter int LVL_BIT = 3,
  parameter int IE_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              push,
  input  logic [7:0]        push_data,
  input  logic              push_special,
  input  logic              pop,
  input  logic              err_reset,
  output logic [7:0]        rd_data,
  output logic              rd_special,
  output logic              char_avail,
  output logic              overrun,
  output logic              irq,
  output logic [7:0]        reg7_q,
  output logic [7:0]        shadow_q
);
  localparam int HALF = DEPTH / 2;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [7:0]      ctl_q;
  logic [CW-1:0]   fill_cnt;
  logic [HALF-1:0] spec_win;
  rx_entry_t       in_entry, head;
  logic            rx_ie, lvl_half;

  assign in_entry = '{spec: push_special, data: push_data};
  assign rx_ie    = ctl_q[IE_BIT];
  assign lvl_half = shadow_q[LVL_BIT];

  rxf_cfg_regs #(.ADDR_W(ADDR_W), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl_q(ctl_q), .reg7_q(reg7_q), .shadow_q(shadow_q)
  );

  rxf_store #(.DEPTH(DEPTH), .HALF(HALF)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_entry(in_entry),
    .pop(pop), .err_clr(err_reset), .head(head), .count(fill_cnt),
    .ovr_q(overrun), .spec_win(spec_win)
  );

  rxf_irq_gen #(.DEPTH(DEPTH), .HALF(HALF)) u_irq (
    .rx_ie(rx_ie), .lvl_half(lvl_half), .count(fill_cnt),
    .spec_win(spec_win), .irq(irq)
  );

  assign rd_data    = head.data;
  assign rd_special = head.spec;
  assign char_avail = (fill_cnt != '0);
endmodule

// File: rtl/rx_fifo_irq_chk.sv
module rx_fifo_irq_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          err_reset,
  input logic [CW-1:0] fill_cnt,
  input logic          overrun,
  input logic          irq,
  input logic          char_avail,
  input logic [7:0]    shadow_q,
  input logic          rx_ie,
  input logic          lvl_half
);
  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && fill_cnt != CW'(DEPTH)) |=> fill_cnt == $past(fill_cnt) + CW'(1));

  p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && fill_cnt == CW'(DEPTH)) |=> overrun);

  p_overrun_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_reset) |=> overrun);

  p_pushpop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && fill_cnt != '0) |=> fill_cnt == $past(fill_cnt));

  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_q[7] == 1'b0);

  p_low_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && !lvl_half && char_avail) |-> irq);

  p_half_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && lvl_half && fill_cnt >= CW'(DEPTH / 2)) |-> irq);

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !irq);

  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && fill_cnt == '0) |=> fill_cnt == '0);
endmodule

bind rx_fifo_irq rx_fifo_irq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .err_reset(err_reset),
  .fill_cnt(fill_cnt), .overrun(overrun), .irq(irq), .char_avail(char_avail),
  .shadow_q(shadow_q), .rx_ie(rx_ie), .lvl_half(lvl_half)
);

// File: tb/rx_fifo_irq_bench.sv
`timescale 1ns/1ps
module rx_fifo_irq_bench;
  localparam int DEPTH = 8;

  logic       clk, rst_n;
  logic       wr_en, push, push_special, pop, err_reset;
  logic [3:0] wr_addr;
  logic [7:0] wr_data, push_data;
  logic [7:0] rd_data, reg7_q, shadow_q;
  logic       rd_special, char_avail, overrun, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [8:0] exp_q[$];

  rx_fifo_irq u_rx_fifo_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .push(push), .push_data(push_data), .push_special(push_special), .pop(pop),
    .err_reset(err_reset), .rd_data(rd_data), .rd_special(rd_special),
    .char_avail(char_avail), .overrun(overrun), .irq(irq), .reg7_q(reg7_q),
    .shadow_q(shadow_q)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares head on every accepted pop, records accepted pushes
  always @(negedge clk) begin : mon
    int pre;
    if (rst_n && !done) begin
      pre = exp_q.size();
      if (pop && pre > 0) begin
        check("R2 head order", {rd_special, rd_data}, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (push && (pre < DEPTH || (pop && pre > 0)))
        exp_q.push_back({push_special, push_data});
    end
  end

  task automatic step();
    @(posedge clk); #1;
    wr_en = 0; push = 0; pop = 0; err_reset = 0; push_special = 0;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic push_one(input logic [7:0] d, input logic s);
    push = 1; push_data = d; push_special = s; step();
  endtask

  task automatic pop_one();
    pop = 1; step();
  endtask

  task automatic push_pop(input logic [7:0] d, input logic s);
    push = 1; push_data = d; push_special = s; pop = 1; step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rst_n = 0; wr_en = 0; push = 0; pop = 0; err_reset = 0; push_special = 0;
    wr_addr = 0; wr_data = 0; push_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    check("R1 char_avail", char_avail, 0);
    check("R1 overrun", overrun, 0);
    check("R1 irq", irq, 0);
    check("R1 reg7", reg7_q, 0);
    check("R1 shadow", shadow_q, 0);

    // R9: interrupt disabled, character held
    push_one(8'h11, 1'b0);
    check("R9 irq off", irq, 0);
    check("R2 char_avail", char_avail, 1);
    pop_one();

    reg_wr(4'd1, 8'h10);           // enable receive interrupt (bit 4)
    reg_wr(4'd7, 8'h5A);           // redirect off
    check("R5 reg7", reg7_q, 8'h5A);
    check("R5 shadow kept", shadow_q, 0);
    reg_wr(4'd15, 8'h01);
    reg_wr(4'd7, 8'hFF);
    check("R6 shadow bit7 zero", shadow_q, 8'h7F);
    check("R5 reg7 kept", reg7_q, 8'h5A);
    reg_wr(4'd7, 8'h00);

    // R7: one-character level
    push_one(8'hA1, 1'b0);
    check("R7 irq one char", irq, 1);
    pop_one();
    check("R10 irq falls", irq, 0);

    // R8: half-full level
    reg_wr(4'd7, 8'h08);
    push_one(8'hB1, 1'b0);
    push_one(8'hB2, 1'b0);
    push_one(8'hB3, 1'b0);
    check("R8 irq below half", irq, 0);
    push_one(8'hB4, 1'b0);
    check("R8 irq at half", irq, 1);
    pop_one();
    check("R10 irq falls below half", irq, 0);
    pop_one(); pop_one(); pop_one();

    // R8: flagged character forces early interrupt
    push_one(8'hC1, 1'b0);
    push_one(8'hC2, 1'b0);
    check("R8 no flag", irq, 0);
    push_one(8'hC3, 1'b1);
    check("R8 early flag irq", irq, 1);
    pop_one(); pop_one();
    check("R2 head flag", rd_special, 1);
    pop_one();
    check("R10 irq after flag pop", irq, 0);

    // R9 at half-full level
    for (int i = 0; i < 4; i++) push_one(8'hD0 + 8'(i), 1'b0);
    check("R8 irq four held", irq, 1);
    reg_wr(4'd1, 8'h00);
    check("R9 irq disabled", irq, 0);
    for (int i = 0; i < 4; i++) pop_one();

    // R3/R4: full queue
    for (int i = 0; i < DEPTH; i++) push_one(8'hE0 + 8'(i), 1'b0);
    push_one(8'hEE, 1'b0);
    check("R3 overrun set", overrun, 1);
    pop = 1; step();   // pop without clearing: flag stays
    check("R3 overrun sticky", overrun, 1);
    err_reset = 1; step();
    check("R3 overrun cleared", overrun, 0);
    push_one(8'hE8, 1'b0);  // refill to full
    push_one(8'hEF, 1'b0);
    err_reset = 1; push = 1; push_data = 8'hF0; step();
    check("R3 set wins over clear", overrun, 1);
    err_reset = 1; step();
    push_pop(8'hF1, 1'b1);
    check("R4 no overrun on push+pop full", overrun, 0);
    check("R4 still holding", char_avail, 1);
    for (int i = 0; i < DEPTH; i++) pop_one();
    check("R4 drained after 8", char_avail, 0);

    // R11: pop on empty
    pop_one();
    check("R11 still empty", char_avail, 0);
    check("R11 overrun untouched", overrun, 0);
    push_one(8'h3C, 1'b0);
    check("R11 push after empty pop", char_avail, 1);
    check("R11 data", rd_data, 8'h3C);
    pop_one();
    check("R2 scoreboard empty", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule